// File: doc/BRIEF.md
# Multi-Plane Request Pairing Scheduler

This block accepts page requests one at a time, each naming a die, a plane and a page offset, and turns them into issue descriptors for a set of dies that share a single I/O bus. Each descriptor names one target die, a mask of the planes that take part, and the page offset. The block either pairs two requests into one two-plane operation on a single die, or spreads single-plane requests over the dies in turn.

The choice comes from a policy input. Under plane-first, the scheduler holds the first request and waits a bounded number of cycles for a partner. A partner must target the same die and the same page offset, and must use a different plane. A request that does not meet this rule is left waiting at the input. When the wait runs out, the held request is issued alone. Under die-first, every request is issued alone. Its target die comes from a rotating pointer, and the die field of the request is ignored.

Only one descriptor can be outstanding at a time, so only one die owns the shared bus at once. A descriptor is not presented while its target die reports busy.

Top module: `mpPairSched`

## Requirements
- R1: After reset, `issValid` is 0 and `reqReady` is 1. The die-first rotation pointer starts at die 0.
- R2: Under plane-first (`policyDieFirst`=0), a second request is merged with the held one when it has the same die, the same page offset and a different plane. The merge gives one descriptor: die of the pair, page of the pair, and `issMask` bit p set for each plane p used (two bits set).
- R3: While a request is held under plane-first, `reqReady` is 0 for a presented request that differs in die or in page, or that uses the same plane. Such a request is not accepted.
- R4: If no partner is accepted, the held request is issued alone with a one-hot `issMask`. `issValid` rises WAIT_CYCLES+1 cycles after the clock edge that accepted it, provided its die is idle.
- R5: Under die-first, each accepted request gives one descriptor with a one-hot `issMask` bit equal to its plane. Its die is the rotating pointer, which steps by one per accepted request and wraps from NUM_DIES-1 to 0. The request's die field has no effect.
- R6: A descriptor is not presented while `dieBusy[die]` is 1. It is presented in the cycle after the target die is seen idle.
- R7: While a descriptor is pending, it stays valid with stable fields until `issReady`. `reqReady` is 0 from the moment a request is accepted until the handshake completes.
- R8: The policy is sampled only when a request is accepted while no request is held. Changing the policy during a hold does not stop the hold from pairing.
- R9: A valid partner that arrives in the last cycle of the wait is merged rather than timed out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| policyDieFirst | input | 1 | 1 selects die-first striping, 0 selects plane-first pairing |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted this cycle when high with reqValid |
| reqDie | input | $clog2(NUM_DIES) | Die named by the request |
| reqPlane | input | $clog2(NUM_PLANES) | Plane named by the request |
| reqPage | input | PAGE_W | Page offset within the block |
| dieBusy | input | NUM_DIES | Per-die busy flags |
| issValid | output | 1 | Descriptor present |
| issReady | input | 1 | Descriptor taken |
| issDie | output | $clog2(NUM_DIES) | Target die of the descriptor |
| issMask | output | NUM_PLANES | Planes that take part |
| issPage | output | PAGE_W | Page offset of the descriptor |

## Verification
A wrong hold register or a faulty pairing compare shows at the ports as a wrong `reqReady` in the same cycle a request is presented. It then shows as a mask with one bit where two were due, or the reverse, on the next descriptor. A wrong wait counter moves the rising edge of `issValid` by whole cycles, and a wrong rotation pointer puts the wrong die on the next die-first descriptor. The bench runs its own model of the scheduler beside the design and compares every output on every clock, so any of these errors is reported in the first cycle it reaches a port.

// File: rtl/mpSchedPkg.sv
package mpSchedPkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_HOLD   = 2'd1,
    ST_LAUNCH = 2'd2,
    ST_ISSUE  = 2'd3
  } schedStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic loadHold;    // capture first request of a candidate pair
    logic tickTimer;   // one more cycle spent waiting for a partner
    logic takePair;    // build a two-plane descriptor from hold + input
    logic takeSingle;  // build a single-plane descriptor from hold
    logic takeDirect;  // build a striped descriptor from input, step pointer
  } stepT;

endpackage

// File: rtl/mpPairCtrl.sv
module mpPairCtrl
  import mpSchedPkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic policyDieFirst,
  input  logic reqValid,
  input  logic issReady,
  input  logic pairOk,
  input  logic timeUp,
  input  logic targetBusy,
  output logic reqReady,
  output logic issValid,
  output stepT step
);

  schedStateT state, nextState;

  always_comb begin
    step      = '0;
    reqReady  = 1'b0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          if (policyDieFirst) begin
            step.takeDirect = 1'b1;
            nextState       = ST_LAUNCH;
          end else begin
            step.loadHold = 1'b1;
            nextState     = ST_HOLD;
          end
        end
      end
      ST_HOLD: begin
        reqReady = pairOk;
        if (reqValid && pairOk) begin
          step.takePair = 1'b1;
          nextState     = ST_LAUNCH;
        end else if (timeUp) begin
          step.takeSingle = 1'b1;
          nextState       = ST_LAUNCH;
        end else begin
          step.tickTimer = 1'b1;
        end
      end
      ST_LAUNCH: begin
        if (!targetBusy) nextState = ST_ISSUE;
      end
      ST_ISSUE: begin
        if (issReady) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nextState;
  end

  assign issValid = (state == ST_ISSUE);

  // R3: a held request never coexists with acceptance of a rule breaker
  p_hold_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD && reqValid && !pairOk) |-> !reqReady);

endmodule

// File: rtl/mpPairPath.sv
module mpPairPath
  import mpSchedPkg::*;
#(
  parameter int NUM_DIES    = 4,
  parameter int NUM_PLANES  = 2,
  parameter int PAGE_W      = 8,
  parameter int WAIT_CYCLES = 4,
  localparam int DIE_W   = $clog2(NUM_DIES),
  localparam int PLANE_W = $clog2(NUM_PLANES),
  localparam int CNT_W   = $clog2(WAIT_CYCLES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  stepT                  step,
  input  logic [DIE_W-1:0]      reqDie,
  input  logic [PLANE_W-1:0]    reqPlane,
  input  logic [PAGE_W-1:0]     reqPage,
  input  logic [NUM_DIES-1:0]   dieBusy,
  output logic                  pairOk,
  output logic                  timeUp,
  output logic                  targetBusy,
  output logic [DIE_W-1:0]      issDie,
  output logic [NUM_PLANES-1:0] issMask,
  output logic [PAGE_W-1:0]     issPage
);

  logic [DIE_W-1:0]      holdDie, diePtr, outDie;
  logic [PLANE_W-1:0]    holdPlane;
  logic [PAGE_W-1:0]     holdPage, outPage;
  logic [CNT_W-1:0]      waitCnt;
  logic [NUM_PLANES-1:0] reqHot, holdHot, outMask;

  for (genvar p = 0; p < NUM_PLANES; p++) begin : g_hot
    assign reqHot[p]  = (reqPlane  == PLANE_W'(p));
    assign holdHot[p] = (holdPlane == PLANE_W'(p));
  end

  assign pairOk = (reqDie == holdDie) && (reqPage == holdPage) &&
                  (reqPlane != holdPlane);
  assign timeUp = (waitCnt == CNT_W'(WAIT_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      holdDie   <= '0;
      holdPlane <= '0;
      holdPage  <= '0;
      waitCnt   <= '0;
    end else if (step.loadHold) begin
      holdDie   <= reqDie;
      holdPlane <= reqPlane;
      holdPage  <= reqPage;
      waitCnt   <= '0;
    end else if (step.tickTimer) begin
      waitCnt   <= waitCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      diePtr  <= '0;
      outDie  <= '0;
      outMask <= '0;
      outPage <= '0;
    end else begin
      if (step.takeDirect) begin
        outDie  <= diePtr;
        outMask <= reqHot;
        outPage <= reqPage;
        diePtr  <= (diePtr == DIE_W'(NUM_DIES - 1)) ? '0 : diePtr + DIE_W'(1);
      end
      if (step.takePair) begin
        outDie  <= holdDie;
        outMask <= holdHot | reqHot;
        outPage <= holdPage;
      end
      if (step.takeSingle) begin
        outDie  <= holdDie;
        outMask <= holdHot;
        outPage <= holdPage;
      end
    end
  end

  assign targetBusy = dieBusy[outDie];
  assign issDie     = outDie;
  assign issMask    = outMask;
  assign issPage    = outPage;

  // R4: the wait counter never runs past the configured window
  p_wait_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step.tickTimer |=> (waitCnt <= CNT_W'(WAIT_CYCLES - 1)));

endmodule

// File: rtl/mpPairSched.sv
module mpPairSched
  import mpSchedPkg::*;
#(
  parameter int NUM_DIES    = 4,
  parameter int NUM_PLANES  = 2,
  parameter int PAGE_W      = 8,
  parameter int WAIT_CYCLES = 4,
  localparam int DIE_W   = $clog2(NUM_DIES),
  localparam int PLANE_W = $clog2(NUM_PLANES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  policyDieFirst,
  input  logic                  reqValid,
  output logic                  reqReady,
  input  logic [DIE_W-1:0]      reqDie,
  input  logic [PLANE_W-1:0]    reqPlane,
  input  logic [PAGE_W-1:0]     reqPage,
  input  logic [NUM_DIES-1:0]   dieBusy,
  output logic                  issValid,
  input  logic                  issReady,
  output logic [DIE_W-1:0]      issDie,
  output logic [NUM_PLANES-1:0] issMask,
  output logic [PAGE_W-1:0]     issPage
);

  stepT step;
  logic pairOk, timeUp, targetBusy;

  mpPairCtrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .policyDieFirst(policyDieFirst),
    .reqValid(reqValid), .issReady(issReady), .pairOk(pairOk),
    .timeUp(timeUp), .targetBusy(targetBusy), .reqReady(reqReady),
    .issValid(issValid), .step(step)
  );

  mpPairPath #(
    .NUM_DIES(NUM_DIES), .NUM_PLANES(NUM_PLANES),
    .PAGE_W(PAGE_W), .WAIT_CYCLES(WAIT_CYCLES)
  ) path_i (
    .clk(clk), .rst_n(rst_n), .step(step), .reqDie(reqDie),
    .reqPlane(reqPlane), .reqPage(reqPage), .dieBusy(dieBusy),
    .pairOk(pairOk), .timeUp(timeUp), .targetBusy(targetBusy),
    .issDie(issDie), .issMask(issMask), .issPage(issPage)
  );

  // R7: a pending descriptor holds its fields until taken
  p_desc_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (issValid && !issReady) |=> (issValid && $stable(issDie) &&
                                 $stable(issMask) && $stable(issPage)));

  // R7: single bus owner, no intake while a descriptor is out
  p_single_owner_r7: assert property (@(posedge clk) disable iff (!rst_n)
    issValid |-> !reqReady);

  // R6: a descriptor appears only after its die was seen idle
  p_idle_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (issValid && !$past(issValid)) |-> !$past(dieBusy[issDie]));

  // R2: one or two planes per descriptor
  p_mask_weight_r2: assert property (@(posedge clk) disable iff (!rst_n)
    issValid |-> ($countones(issMask) == 1 || $countones(issMask) == 2));

endmodule

// File: tb/mpPairSched_tb.sv
module mpPairSched_tb_top;

  localparam int ND = 4;
  localparam int NP = 2;
  localparam int PW = 8;
  localparam int WT = 4;
  localparam int DW = $clog2(ND);
  localparam int LW = $clog2(NP);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic policyDieFirst = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [DW-1:0] reqDie = '0;
  logic [LW-1:0] reqPlane = '0;
  logic [PW-1:0] reqPage = '0;
  logic [ND-1:0] dieBusy = '0;
  logic issValid;
  logic issReady = 1'b1;
  logic [DW-1:0] issDie;
  logic [NP-1:0] issMask;
  logic [PW-1:0] issPage;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  mpPairSched #(.NUM_DIES(ND), .NUM_PLANES(NP), .PAGE_W(PW), .WAIT_CYCLES(WT)) dut_i (
    .clk(clk), .rst_n(rst_n), .policyDieFirst(policyDieFirst),
    .reqValid(reqValid), .reqReady(reqReady), .reqDie(reqDie),
    .reqPlane(reqPlane), .reqPage(reqPage), .dieBusy(dieBusy),
    .issValid(issValid), .issReady(issReady), .issDie(issDie),
    .issMask(issMask), .issPage(issPage)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: phase 0 idle, 1 waiting for partner, 2 waiting for die, 3 offered
  int mPhase = 0, mHDie = 0, mHPl = 0, mHPg = 0, mWait = 0, mPtr = 0;
  int mODie = 0, mOMask = 0, mOPg = 0;

  function automatic bit partner();
    return (int'(reqDie) == mHDie) && (int'(reqPage) == mHPg) && (int'(reqPlane) != mHPl);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      mPhase = 0; mWait = 0; mPtr = 0; mODie = 0; mOMask = 0; mOPg = 0;
    end else begin
      case (mPhase)
        0: if (reqValid) begin
             if (policyDieFirst) begin
               mODie = mPtr; mOMask = 1 << reqPlane; mOPg = int'(reqPage);
               mPtr = (mPtr + 1) % ND; mPhase = 2;
             end else begin
               mHDie = int'(reqDie); mHPl = int'(reqPlane); mHPg = int'(reqPage);
               mWait = 0; mPhase = 1;
             end
           end
        1: if (reqValid && partner()) begin
             mODie = mHDie; mOMask = (1 << mHPl) | (1 << reqPlane); mOPg = mHPg; mPhase = 2;
           end else if (mWait == WT - 1) begin
             mODie = mHDie; mOMask = 1 << mHPl; mOPg = mHPg; mPhase = 2;
           end else mWait++;
        2: if (!dieBusy[mODie]) mPhase = 3;
        default: if (issReady) mPhase = 0;
      endcase
    end
  end

  // issued descriptor log
  int logDie[$], logMask[$], logPage[$], logRise[$];
  bit prevValid = 1'b0;
  int riseCyc = 0;

  always @(negedge clk) begin
    #3;
    begin
      bit expReady;
      expReady = (mPhase == 0) ? 1'b1 : (mPhase == 1) ? partner() : 1'b0;
      check(reqReady == expReady, "R3/R7 reqReady vs model (R7 R3)", int'(reqReady), int'(expReady));
      check(issValid == (mPhase == 3), "R6 issValid vs model", int'(issValid), int'(mPhase == 3));
      if (issValid && mPhase == 3) begin
        check(int'(issDie) == mODie, "R5 issDie vs model", int'(issDie), mODie);
        check(int'(issMask) == mOMask, "R2 issMask vs model", int'(issMask), mOMask);
        check(int'(issPage) == mOPg, "R2 issPage vs model", int'(issPage), mOPg);
      end
    end
    if (issValid && !prevValid) riseCyc = cyc;
    prevValid = issValid;
    if (issValid && issReady) begin
      logDie.push_back(int'(issDie)); logMask.push_back(int'(issMask));
      logPage.push_back(int'(issPage)); logRise.push_back(riseCyc);
    end
  end

  task automatic drive(input int d, input int p, input int pg);
    reqDie = DW'(d); reqPlane = LW'(p); reqPage = PW'(pg); reqValid = 1'b1;
  endtask

  task automatic sendReq(input int d, input int p, input int pg, output int accCyc);
    bit done;
    done = 1'b0;
    drive(d, p, pg);
    while (!done) begin
      #3;
      if (reqReady) begin done = 1'b1; accCyc = cyc; end
      @(negedge clk);
    end
    reqValid = 1'b0;
  endtask

  task automatic offerReq(input int d, input int p, input int pg, input int n, output bit got);
    got = 1'b0;
    drive(d, p, pg);
    for (int i = 0; i < n; i++) begin
      #3;
      if (reqReady) got = 1'b1;
      @(negedge clk);
    end
    reqValid = 1'b0;
  endtask

  task automatic waitLog(input int n);
    for (int i = 0; i < 100 && logDie.size() < n; i++) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int acc;
    bit got;
    repeat (3) @(negedge clk);
    #3;
    check(issValid == 1'b0, "R1 reset issValid", int'(issValid), 0);
    check(reqReady == 1'b1, "R1 reset reqReady", int'(reqReady), 1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 pairing
    sendReq(1, 0, 5, acc);
    sendReq(1, 1, 5, acc);
    waitLog(1);
    check(logDie.size() == 1, "R2 one descriptor for pair", logDie.size(), 1);
    check(logMask[0] == 3, "R2 pair mask", logMask[0], 3);
    check(logDie[0] == 1 && logPage[0] == 5, "R2 pair die/page", logDie[0]*256 + logPage[0], 256 + 5);

    // R3 rule breakers refused, then R4 single issue
    sendReq(2, 0, 7, acc);
    offerReq(3, 1, 7, 1, got);
    check(!got, "R3 other die refused", int'(got), 0);
    offerReq(2, 0, 7, 1, got);
    check(!got, "R3 same plane refused", int'(got), 0);
    offerReq(2, 1, 8, 1, got);
    check(!got, "R3 other page refused", int'(got), 0);
    waitLog(2);
    check(logMask[1] == 1 && logDie[1] == 2, "R4 single after timeout", logMask[1], 1);

    // R4 timing of lone issue
    sendReq(0, 1, 3, acc);
    waitLog(3);
    check(logMask[2] == 2, "R4 lone mask", logMask[2], 2);
    check(logRise[2] == acc + WT + 2, "R4 issue delay", logRise[2] - acc, WT + 2);

    // R5 die-first striping, R1 pointer starts at 0
    policyDieFirst = 1'b1;
    for (int k = 0; k < 5; k++) sendReq(3, k % 2, 10 + k, acc);
    waitLog(8);
    check(logDie[3] == 0, "R1 R5 first striped die", logDie[3], 0);
    for (int k = 0; k < 5; k++) begin
      check(logDie[3+k] == k % ND, "R5 striped die", logDie[3+k], k % ND);
      check(logMask[3+k] == (1 << (k % 2)), "R5 striped mask", logMask[3+k], 1 << (k % 2));
    end

    // R6 busy die blocks the descriptor
    dieBusy = 4'b0010;
    sendReq(0, 0, 20, acc);
    repeat (5) @(negedge clk);
    #3;
    check(issValid == 1'b0, "R6 held while die busy", int'(issValid), 0);
    @(negedge clk);
    dieBusy = '0;
    waitLog(9);
    check(logDie[8] == 1, "R6 die after release", logDie[8], 1);

    // R7 stall on issReady
    issReady = 1'b0;
    sendReq(0, 1, 21, acc);
    repeat (3) @(negedge clk);
    offerReq(0, 0, 22, 4, got);
    check(!got, "R7 no intake while pending", int'(got), 0);
    #3;
    check(issValid == 1'b1 && int'(issDie) == 2, "R7 still pending", int'(issValid), 1);
    @(negedge clk);
    issReady = 1'b1;
    waitLog(10);
    check(logDie.size() == 10, "R7 exactly one handshake", logDie.size(), 10);

    // R8 policy change during hold
    policyDieFirst = 1'b0;
    sendReq(1, 0, 9, acc);
    policyDieFirst = 1'b1;
    sendReq(1, 1, 9, acc);
    waitLog(11);
    check(logMask[10] == 3 && logDie[10] == 1, "R8 pair kept across policy change", logMask[10], 3);
    policyDieFirst = 1'b0;

    // R9 partner in last wait cycle
    sendReq(0, 0, 2, acc);
    repeat (WT - 1) @(negedge clk);
    sendReq(0, 1, 2, acc);
    waitLog(12);
    check(logDie.size() == 12 && logMask[11] == 3, "R9 merge wins at timeout", logMask[11], 3);

    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule